// File: doc/BRIEF.md
# Serial Food Item Manager

This block keeps the food layout of one game level. A level controller sends it a one-cycle `init_req`. The block then draws a fresh set of grid cells from an internal pseudo-random source and keeps only cells that differ from all the ones already accepted. When every slot is filled it pulses `init_done`, and the remaining-item count reads full.

Once per frame the controller gives the snake-head cell and pulses `check_start`. The block then walks its stored items, comparing one slot against the head in each clock cycle. A live item that matches is deleted. The walk ends with a single-cycle `check_done`, and with `eaten` in that same cycle when something was consumed. The display side can ask at any time whether a given grid cell holds live food through a combinational query port.

The controller moves through four named states. **IDLE** waits for a command. **DRAW** registers a candidate cell from the random source. **VERIFY** compares the candidate against the accepted slots one per cycle: it returns to DRAW on a clash, writes the slot and goes back to DRAW when more slots remain, or writes the last slot and goes to IDLE. **SCAN** walks the slots against the head and returns to IDLE after the last one. An `init_req` seen in any state clears the slots and enters DRAW.

Top module: `food_manager`

## Requirements
- R1: After reset, `init_done`, `check_done` and `eaten` are low, `items_left` is 0, and the query port reports no food at any cell.
- R2: An `init_req` leads to `init_done` high for exactly one cycle. In that same cycle `items_left` equals N_ITEMS (5), and it stays 0 while generation runs.
- R3: After initialization, exactly N_ITEMS distinct cells, all with x < GRID_W and y < GRID_H, report food on the query port.
- R4: A `check_start` accepted in IDLE produces `check_done` high for exactly one cycle, N_ITEMS clock cycles after the edge that sampled the start.
- R5: When the head equals a live item, `eaten` is high in the `check_done` cycle, `items_left` has dropped by exactly one, and that cell no longer reports food.
- R6: When the head matches no live item, `check_done` comes with `eaten` low, and both `items_left` and the food map are unchanged.
- R7: An item that has been eaten stays removed: a later check at its cell gives no `eaten`.
- R8: After every item of a level has been eaten, `items_left` reads 0 and no cell reports food.
- R9: `check_start` has no effect while generation or a walk is running. No extra `check_done` or `eaten` results from it.
- R10: `init_req` during a walk aborts the walk: no `check_done` or `eaten` for it, and a full new layout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start a new layout (any state) |
| init_done | output | 1 | One-cycle pulse: layout ready |
| check_start | input | 1 | Start a head walk (accepted in IDLE only) |
| head_x | input | $clog2(GRID_W) | Head column |
| head_y | input | $clog2(GRID_H) | Head row |
| check_done | output | 1 | One-cycle pulse: walk finished |
| eaten | output | 1 | One-cycle pulse with check_done: an item was removed |
| items_left | output | $clog2(N_ITEMS+1) | Live items remaining |
| qry_x | input | $clog2(GRID_W) | Display query column |
| qry_y | input | $clog2(GRID_H) | Display query row |
| qry_food | output | 1 | Query cell holds live food (combinational) |

## Verification
The walk is driven with head cells taken at random from the current layout, some still live and some already eaten, and with random empty cells. This separates a hit from a stale hit and from a plain miss. Directed cases hit every slot position until the level is empty, which exposes a walk that skips or repeats a slot or a count that drifts. Start pulses are injected during generation and during a walk, and an init is injected mid-walk, to tell ignored commands apart from honoured ones. Each layout is read back cell by cell through the query port, which shows both duplicate placement and items that were removed when they should not have been.

// File: rtl/food_pkg.sv
package food_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAW,
        ST_VERIFY,
        ST_SCAN
    } fm_state_t;

    // Galois form of a maximal-length 16-bit shift register
    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

endpackage

// File: rtl/food_lfsr.sv
module food_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] state_o
);
    import food_pkg::*;

    // a zero seed would lock the register; substitute a fixed value
    localparam logic [15:0] SAFE_SEED = (SEED == 16'h0000) ? 16'h0001 : SEED;

    logic [15:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SAFE_SEED;
        else        state_q <= lfsr_step(state_q);
    end

    assign state_o = state_q;

endmodule

// File: rtl/food_slots.sv
module food_slots #(
    parameter int N_ITEMS = 5,
    parameter int XW      = 6,
    parameter int YW      = 5,
    parameter int IW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [XW-1:0] wr_x,
    input  logic [YW-1:0] wr_y,
    input  logic          kill_en,
    input  logic [IW-1:0] kill_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [XW-1:0] rd_x,
    output logic [YW-1:0] rd_y,
    output logic          rd_v,
    input  logic [XW-1:0] qry_x,
    input  logic [YW-1:0] qry_y,
    output logic          qry_hit
);

    logic [XW-1:0]      sx [N_ITEMS];
    logic [YW-1:0]      sy [N_ITEMS];
    logic [N_ITEMS-1:0] sv;
    logic [N_ITEMS-1:0] hit_vec;

    for (genvar g = 0; g < N_ITEMS; g++) begin : g_slot
        logic          v_q;
        logic [XW-1:0] x_q;
        logic [YW-1:0] y_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                x_q <= '0;
                y_q <= '0;
            end else if (clr_all) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                v_q <= 1'b1;
                x_q <= wr_x;
                y_q <= wr_y;
            end else if (kill_en && (kill_idx == IW'(g))) begin
                v_q <= 1'b0;
            end
        end

        assign sv[g]      = v_q;
        assign sx[g]      = x_q;
        assign sy[g]      = y_q;
        // display-side lookup only; the head search uses the single read port
        assign hit_vec[g] = v_q && (x_q == qry_x) && (y_q == qry_y);
    end

    // single read port: the only path into the head/candidate comparator
    always_comb begin
        rd_x = '0;
        rd_y = '0;
        rd_v = 1'b0;
        for (int i = 0; i < N_ITEMS; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_x = sx[i];
                rd_y = sy[i];
                rd_v = sv[i];
            end
        end
    end

    assign qry_hit = |hit_vec;

endmodule

// File: rtl/food_ctrl.sv
module food_ctrl #(
    parameter int N_ITEMS = 5,
    parameter int GRID_W  = 40,
    parameter int GRID_H  = 30,
    parameter int XW      = 6,
    parameter int YW      = 5,
    parameter int IW      = 3,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_req,
    input  logic          check_start,
    input  logic [XW-1:0] head_x,
    input  logic [YW-1:0] head_y,
    input  logic [15:0]   rnd,
    input  logic [XW-1:0] rd_x,
    input  logic [YW-1:0] rd_y,
    input  logic          rd_v,
    output logic          clr_all,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [XW-1:0] wr_x,
    output logic [YW-1:0] wr_y,
    output logic          kill_en,
    output logic [IW-1:0] kill_idx,
    output logic [IW-1:0] rd_idx,
    output logic          init_done,
    output logic          check_done,
    output logic          eaten,
    output logic [CW-1:0] items_left,
    output logic          fsm_idle
);
    import food_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(N_ITEMS - 1);
    localparam logic [CW-1:0] FULL = CW'(N_ITEMS);

    fm_state_t     st, st_n;
    logic [CW-1:0] slot_k, cmp_j, scan_i, left_q;
    logic [XW-1:0] cand_x, hx;
    logic [YW-1:0] cand_y, hy;
    logic          hit;
    logic          cand_eq, head_eq;
    logic [XW-1:0] draw_x;
    logic [YW-1:0] draw_y;

    // candidate cell: two views of the random word reduced into the grid
    assign draw_x = XW'(32'(rnd) % 32'(GRID_W));
    assign draw_y = YW'(32'({rnd[7:0], rnd[15:8]}) % 32'(GRID_H));

    assign cand_eq = rd_v && (rd_x == cand_x) && (rd_y == cand_y);
    assign head_eq = rd_v && (rd_x == hx) && (rd_y == hy);

    // next state and slot strobes
    always_comb begin
        st_n    = st;
        clr_all = 1'b0;
        wr_en   = 1'b0;
        kill_en = 1'b0;
        rd_idx  = '0;
        if (init_req) begin
            clr_all = 1'b1;
            st_n    = ST_DRAW;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (check_start) st_n = ST_SCAN;
                end
                ST_DRAW: begin
                    st_n = ST_VERIFY;
                end
                ST_VERIFY: begin
                    rd_idx = IW'(cmp_j);
                    if (cmp_j == slot_k) begin
                        wr_en = 1'b1;
                        st_n  = (slot_k == LAST) ? ST_IDLE : ST_DRAW;
                    end else if (cand_eq) begin
                        st_n = ST_DRAW;
                    end
                end
                ST_SCAN: begin
                    rd_idx = IW'(scan_i);
                    if (head_eq && !hit) kill_en = 1'b1;
                    if (scan_i == LAST) st_n = ST_IDLE;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // counters, latched operands and status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_k     <= '0;
            cmp_j      <= '0;
            scan_i     <= '0;
            left_q     <= '0;
            cand_x     <= '0;
            cand_y     <= '0;
            hx         <= '0;
            hy         <= '0;
            hit        <= 1'b0;
            init_done  <= 1'b0;
            check_done <= 1'b0;
            eaten      <= 1'b0;
        end else begin
            init_done  <= 1'b0;
            check_done <= 1'b0;
            eaten      <= 1'b0;
            if (init_req) begin
                slot_k <= '0;
                left_q <= '0;
                hit    <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (check_start) begin
                            hx     <= head_x;
                            hy     <= head_y;
                            scan_i <= '0;
                            hit    <= 1'b0;
                        end
                    end
                    ST_DRAW: begin
                        cand_x <= draw_x;
                        cand_y <= draw_y;
                        cmp_j  <= '0;
                    end
                    ST_VERIFY: begin
                        if (cmp_j == slot_k) begin
                            if (slot_k == LAST) begin
                                init_done <= 1'b1;
                                left_q    <= FULL;
                            end else begin
                                slot_k <= slot_k + 1'b1;
                            end
                        end else if (!cand_eq) begin
                            cmp_j <= cmp_j + 1'b1;
                        end
                    end
                    ST_SCAN: begin
                        if (kill_en) hit <= 1'b1;
                        if (scan_i == LAST) begin
                            check_done <= 1'b1;
                            eaten      <= hit | kill_en;
                            if (hit | kill_en) left_q <= left_q - 1'b1;
                        end else begin
                            scan_i <= scan_i + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_idx     = IW'(slot_k);
    assign wr_x       = cand_x;
    assign wr_y       = cand_y;
    assign kill_idx   = rd_idx;
    assign items_left = left_q;
    assign fsm_idle   = (st == ST_IDLE);

endmodule

// File: rtl/food_manager.sv
module food_manager #(
    parameter int          N_ITEMS = 5,
    parameter int          GRID_W  = 40,
    parameter int          GRID_H  = 30,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         init_req,
    output logic                         init_done,
    input  logic                         check_start,
    input  logic [$clog2(GRID_W)-1:0]    head_x,
    input  logic [$clog2(GRID_H)-1:0]    head_y,
    output logic                         check_done,
    output logic                         eaten,
    output logic [$clog2(N_ITEMS+1)-1:0] items_left,
    input  logic [$clog2(GRID_W)-1:0]    qry_x,
    input  logic [$clog2(GRID_H)-1:0]    qry_y,
    output logic                         qry_food
);

    localparam int XW = $clog2(GRID_W);
    localparam int YW = $clog2(GRID_H);
    localparam int IW = (N_ITEMS > 1) ? $clog2(N_ITEMS) : 1;
    localparam int CW = $clog2(N_ITEMS + 1);

    logic [15:0]   rnd;
    logic          clr_all, wr_en, kill_en, rd_v, fsm_idle;
    logic [IW-1:0] wr_idx, kill_idx, rd_idx;
    logic [XW-1:0] wr_x, rd_x;
    logic [YW-1:0] wr_y, rd_y;

    food_lfsr #(.SEED(SEED)) u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (rnd)
    );

    food_slots #(.N_ITEMS(N_ITEMS), .XW(XW), .YW(YW), .IW(IW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_x     (wr_x),
        .wr_y     (wr_y),
        .kill_en  (kill_en),
        .kill_idx (kill_idx),
        .rd_idx   (rd_idx),
        .rd_x     (rd_x),
        .rd_y     (rd_y),
        .rd_v     (rd_v),
        .qry_x    (qry_x),
        .qry_y    (qry_y),
        .qry_hit  (qry_food)
    );

    food_ctrl #(
        .N_ITEMS(N_ITEMS), .GRID_W(GRID_W), .GRID_H(GRID_H),
        .XW(XW), .YW(YW), .IW(IW), .CW(CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_req    (init_req),
        .check_start (check_start),
        .head_x      (head_x),
        .head_y      (head_y),
        .rnd         (rnd),
        .rd_x        (rd_x),
        .rd_y        (rd_y),
        .rd_v        (rd_v),
        .clr_all     (clr_all),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_x        (wr_x),
        .wr_y        (wr_y),
        .kill_en     (kill_en),
        .kill_idx    (kill_idx),
        .rd_idx      (rd_idx),
        .init_done   (init_done),
        .check_done  (check_done),
        .eaten       (eaten),
        .items_left  (items_left),
        .fsm_idle    (fsm_idle)
    );

endmodule

// File: rtl/food_manager_chk.sv
module food_manager_chk #(
    parameter int N_ITEMS = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         init_req,
    input logic                         check_start,
    input logic                         fsm_idle,
    input logic                         init_done,
    input logic                         check_done,
    input logic                         eaten,
    input logic [$clog2(N_ITEMS+1)-1:0] items_left
);
    localparam int CW = $clog2(N_ITEMS + 1);

    logic       start_acc;
    logic [7:0] since;

    assign start_acc = check_start && !init_req && fsm_idle;

    // cycles elapsed since an accepted start; cleared by completion or init
    always_ff @(posedge clk) begin
        if (!rst_n)              since <= '0;
        else if (init_req)       since <= '0;
        else if (start_acc)      since <= 8'd1;
        else if (check_done)     since <= '0;
        else if (since != 8'd0)  since <= since + 8'd1;
    end

    // R4: completion lands exactly N_ITEMS cycles after the accepted start
    a_r4_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        check_done |-> (since == 8'(N_ITEMS + 1)));

    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        check_done |=> !check_done);

    a_r2_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);

    a_r2_init_full: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (items_left == CW'(N_ITEMS)));

    a_r5_eaten_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        eaten |-> check_done);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        eaten |-> (items_left == CW'($past(items_left) - 1'b1)));

    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (check_done && !eaten) |-> $stable(items_left));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        items_left <= CW'(N_ITEMS));

    // R9: a walk never completes without a start having been accepted
    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        check_done |-> $past(since != 8'd0));

endmodule

bind food_manager food_manager_chk #(.N_ITEMS(N_ITEMS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_req    (init_req),
    .check_start (check_start),
    .fsm_idle    (fsm_idle),
    .init_done   (init_done),
    .check_done  (check_done),
    .eaten       (eaten),
    .items_left  (items_left)
);

// File: tb/food_manager_test.sv
`timescale 1ns/1ps
module food_manager_test;

    localparam int N  = 5;
    localparam int GW = 40;
    localparam int GH = 30;
    localparam int XW = $clog2(GW);
    localparam int YW = $clog2(GH);
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_req = 1'b0;
    logic          check_start = 1'b0;
    logic [XW-1:0] head_x = '0;
    logic [YW-1:0] head_y = '0;
    logic [XW-1:0] qry_x = '0;
    logic [YW-1:0] qry_y = '0;
    logic          init_done, check_done, eaten, qry_food;
    logic [CW-1:0] items_left;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;

    // bench model of the live layout
    int  fx [N];
    int  fy [N];
    bit  fl [N];

    food_manager #(.N_ITEMS(N), .GRID_W(GW), .GRID_H(GH)) uut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_done(init_done),
        .check_start(check_start), .head_x(head_x), .head_y(head_y),
        .check_done(check_done), .eaten(eaten), .items_left(items_left),
        .qry_x(qry_x), .qry_y(qry_y), .qry_food(qry_food)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_find(input int x, input int y);
        for (int i = 0; i < N; i++)
            if (fl[i] && fx[i] == x && fy[i] == y) return i;
        return -1;
    endfunction

    function automatic int model_left();
        int n = 0;
        for (int i = 0; i < N; i++) if (fl[i]) n++;
        return n;
    endfunction

    // read the layout through the query port into the model
    task automatic learn_layout(input string req);
        int n = 0;
        for (int i = 0; i < N; i++) fl[i] = 0;
        for (int x = 0; x < (1 << XW); x++) begin
            for (int y = 0; y < (1 << YW); y++) begin
                qry_x = XW'(x); qry_y = YW'(y); #1;
                if (qry_food) begin
                    if (n < N && x < GW && y < GH) begin
                        fx[n] = x; fy[n] = y; fl[n] = 1;
                    end
                    n++;
                end
            end
        end
        chk(n == N, req, n, N);
    endtask

    // compare every cell against the model
    task automatic verify_map(input string req);
        int bad = 0;
        for (int x = 0; x < (1 << XW); x++) begin
            for (int y = 0; y < (1 << YW); y++) begin
                qry_x = XW'(x); qry_y = YW'(y); #1;
                if (qry_food != (model_find(x, y) >= 0)) bad++;
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic wait_init(input string req);
        bit got = 0;
        bit stray = 0;
        for (int c = 0; c < 4000 && !got; c++) begin
            @(negedge clk);
            if (check_done || eaten) stray = 1;
            if (init_done) got = 1;
        end
        chk(got, {req, " init_done"}, got, 1);
        chk(!stray, "R9 R10 no walk result during init", stray, 0);
        chk(items_left == CW'(N), "R2 count full", items_left, N);
        @(negedge clk);
        chk(!init_done, "R2 init_done one cycle", init_done, 0);
    endtask

    task automatic do_init(input bit noise);
        @(negedge clk); init_req = 1;
        @(negedge clk); init_req = 0;
        chk(items_left == 0, "R2 count zero while generating", items_left, 0);
        if (noise) begin
            check_start = 1;
            repeat (3) @(negedge clk);
            check_start = 0;
        end
        wait_init("R2");
    endtask

    // one walk; extra=1 pulses check_start again mid-walk (R9)
    task automatic do_check(input int x, input int y, input bit extra);
        int  idx = model_find(x, y);
        bit  exp_eat = (idx >= 0);
        int  exp_left = int'(items_left) - (exp_eat ? 1 : 0);
        string tag = exp_eat ? "R5" : "R6";
        bit  early = 0;
        @(negedge clk);
        head_x = XW'(x); head_y = YW'(y); check_start = 1;
        @(negedge clk);
        check_start = 0;
        if (check_done) early = 1;
        for (int c = 2; c <= 5; c++) begin
            if (extra) check_start = (c <= 3);
            @(negedge clk);
            if (check_done) early = 1;
        end
        check_start = 0;
        chk(!early, "R4 no early done", early, 0);
        @(negedge clk);
        chk(check_done, "R4 done after N cycles", check_done, 1);
        chk(eaten == exp_eat, {tag, " eaten"}, eaten, exp_eat);
        chk(int'(items_left) == exp_left, {tag, " count"}, items_left, exp_left);
        if (exp_eat) fl[idx] = 0;
        qry_x = XW'(x); qry_y = YW'(y); #1;
        chk(qry_food == (model_find(x, y) >= 0), {tag, " cell after walk"}, qry_food, 0);
        @(negedge clk);
        chk(!check_done, "R4 done one cycle", check_done, 0);
        if (extra) begin
            bit again = 0;
            repeat (8) begin
                @(negedge clk);
                if (check_done) again = 1;
            end
            chk(!again, "R9 mid-walk start ignored", again, 0);
        end
    endtask

    initial begin
        int unsigned seed_v = $urandom(32'd20240607);
        if (seed_v == 0) seed_v = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!init_done, "R1 init_done", init_done, 0);
        chk(!check_done, "R1 check_done", check_done, 0);
        chk(!eaten, "R1 eaten", eaten, 0);
        chk(items_left == 0, "R1 items_left", items_left, 0);
        for (int i = 0; i < N; i++) fl[i] = 0;
        verify_map("R1 empty map");
        // walk on an empty set: a miss
        do_check(3, 4, 0);

        for (int lv = 0; lv < 6; lv++) begin
            do_init(lv == 0);  // R9: start pulses during generation
            learn_layout("R3 distinct in-grid items");
            if (lv == 0) begin
                int k = 0;
                do_check(fx[k], fy[k], 1);   // R5 hit with R9 mid-walk start
                do_check(fx[k], fy[k], 0);   // R7 stale hit
                chk(model_find(fx[k], fy[k]) < 0, "R7 stays removed", 0, 0);
            end
            for (int t = 0; t < 20; t++) begin
                int r = int'($urandom % 3);
                if (r == 0) begin
                    int k = int'($urandom % N);
                    do_check(fx[k], fy[k], 0);
                end else begin
                    do_check(int'($urandom % GW), int'($urandom % GH), 0);
                end
            end
            verify_map("R6 map consistent");
            if (lv == 2) begin
                // R10: abort a walk on a live item with a new init
                int k = 0;
                while (k < N && !fl[k]) k++;
                if (k == N) k = 0;
                @(negedge clk);
                head_x = XW'(fx[k]); head_y = YW'(fy[k]); check_start = 1;
                @(negedge clk); check_start = 0;
                @(negedge clk); init_req = 1;
                @(negedge clk); init_req = 0;
                wait_init("R10");
                learn_layout("R10 fresh layout");
            end
            for (int k = 0; k < N; k++) if (fl[k]) do_check(fx[k], fy[k], 0);
            chk(items_left == 0, "R8 level emptied", items_left, 0);
            chk(model_left() == 0, "R8 model empty", model_left(), 0);
            verify_map("R8 no food left");
            do_check(fx[N-1], fy[N-1], 0);  // R7 eaten cell stays empty
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule